// File: doc/BRIEF.md
# Autonomous Watchdog and Wake Timer

This block is a timer that runs from a slow, always-on tick and serves three purposes through one counter. While the device is in RUN mode, it is a CPU watchdog. Software must restart the count before it expires, or the block requests a system reset. While the device is in STOP mode, it can raise a periodic interrupt that also requests a wake-up. Also in STOP mode, it can power a small group of sensor inputs once per period, sample them after a settle delay, and request a wake-up when any of them reads high.

Software controls the block through one byte-wide control register. That register holds the enables, a period select, a timeout flag that is cleared by writing 1, and a restart command. The reset enable can only be set; a later software write cannot clear it. The counter runs only while at least one of the three function enables is set. When all three are clear, the timer is idle and its count is held at zero.

Top module: `wake_watchdog`

## Requirements
- R1: All control bits, the flag and every output are 0 after reset. Register bits 7, 6 and 5 always read 0. Bit 5 is the restart command, bit 4 the reset enable, bit 3 the interrupt enable, bit 2 the cyclic-check enable, bit 1 the timeout flag and bit 0 the period select.
- R2: When the reset, interrupt and cyclic-check enables are all 0, the counter is held at zero and no timeout occurs, however many ticks arrive.
- R3: Writing 1 to bit 4 sets the reset enable. A later write of 0 to bit 4 leaves it set until the next reset.
- R4: In RUN mode with the reset enable set, the tick that completes a period asserts `reset_req` after that edge. `reset_req` stays high until reset.
- R5: In STOP mode with neither the interrupt nor the cyclic-check enable set, the count is frozen. It resumes from the same value when RUN mode returns.
- R6: Writing 1 to bit 5 clears the counter, so a full new period is needed before a timeout.
- R7: A timeout sets the flag (bit 1). Writing 1 to bit 1 clears the flag and restarts the counter. Writing 0 to bit 1 leaves the flag unchanged.
- R8: `irq_req` and `wake_req` are high only while in STOP mode with the interrupt enable and the flag both set. In RUN mode, a set flag raises neither.
- R9: A period lasts PERIOD_SHORT ticks (16 by default) when bit 0 is 0, and PERIOD_LONG ticks (32 by default) when bit 0 is 1.
- R10: In STOP mode with the cyclic check enabled, each timeout raises `sense_pwr` for SETTLE_TICKS ticks (3 by default). At the last of those ticks the inputs are sampled and `sense_pwr` drops. If any input is 1 and `sense_wake_en` is 1, `wake_req` is set. It stays set until RUN mode returns or the cyclic check is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| stop_mode | input | 1 | 1 = STOP mode, 0 = RUN mode |
| tick_en | input | 1 | One-cycle tick from the slow oscillator |
| sense_in | input | NUM_SENSE | Sensor sample inputs |
| sense_wake_en | input | 1 | Allows a sensor hit to request wake-up |
| sense_pwr | output | 1 | Sensor power strobe |
| reset_req | output | 1 | System reset request |
| irq_req | output | 1 | Periodic interrupt request |
| wake_req | output | 1 | Wake-up request |

## Verification
The block has only a few internal state elements: the counter, the latched control bits and the sensing state. Each one shows up at a port within one period.
- A counter that slips by even one count moves the edge at which the flag or `reset_req` appears. So every timeout is checked on the exact expected edge, one cycle early and on time.
- A reset enable that can be cleared, or a flag that ignores a write of 1, is visible on the register read port after the next write.
- A frozen or free-running count in STOP mode shifts the first timeout after RUN mode returns.
- A settle count that is off by one changes the width of `sense_pwr` and the edge at which `wake_req` rises.

// File: rtl/wake_wdt_pkg.sv
package wake_wdt_pkg;

    // Bit positions in the control register.
    localparam int BIT_RESTART = 5;
    localparam int BIT_RST_EN  = 4;
    localparam int BIT_IRQ_EN  = 3;
    localparam int BIT_CYC_EN  = 2;
    localparam int BIT_FLAG    = 1;
    localparam int BIT_SEL     = 0;

    typedef struct packed {
        logic rst_en;
        logic irq_en;
        logic cyc_en;
        logic flag;
        logic sel;
    } ctrl_t;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_SETTLE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wake_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       timeout,
    output ctrl_t      ctrl,
    output logic       restart,
    output logic [7:0] rdata
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.irq_en = wdata[BIT_IRQ_EN];
            ctrl_d.cyc_en = wdata[BIT_CYC_EN];
            ctrl_d.sel    = wdata[BIT_SEL];
            // The reset enable can be set by a write but never cleared by one.
            ctrl_d.rst_en = ctrl_q.rst_en | wdata[BIT_RST_EN];
            if (wdata[BIT_FLAG]) begin
                ctrl_d.flag = 1'b0;
            end
        end
        // A timeout in the same cycle as a clear leaves the flag set.
        if (timeout) begin
            ctrl_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl    = ctrl_q;
    assign restart = wr_en & (wdata[BIT_RESTART] | wdata[BIT_FLAG]);
    assign rdata   = {3'b000, ctrl_q.rst_en, ctrl_q.irq_en, ctrl_q.cyc_en,
                      ctrl_q.flag, ctrl_q.sel};

    assert_rst_en_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.rst_en |=> ctrl_q.rst_en);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[BIT_FLAG] && !timeout) |=> !ctrl_q.flag);

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.flag && !(wr_en && wdata[BIT_FLAG])) |=> ctrl_q.flag);

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int PERIOD_SHORT = 16,
    parameter int PERIOD_LONG  = 32,
    localparam int CNT_W = $clog2(PERIOD_LONG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic count_en,
    input  logic restart,
    input  logic sel,
    output logic timeout
);

    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(PERIOD_SHORT - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(PERIOD_LONG - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        st_d    = st_q;
        timeout = 1'b0;
        last_d  = sel ? LONG_LAST : SHORT_LAST;
        if (!active || restart) begin
            st_d.cnt = '0;
        end else if (count_en && tick) begin
            // Compare with >= so that switching to the short period
            // in the middle of a long one still ends the period.
            if (st_q.cnt >= last_d) begin
                st_d.cnt = '0;
                timeout  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.cnt == '0));

    assert_restart_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && restart) |=> (st_q.cnt == '0));

    assert_no_count_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (st_q.cnt <= LONG_LAST));

endmodule

// File: rtl/wdt_sense_seq.sv
module wdt_sense_seq
    import wake_wdt_pkg::*;
#(
    parameter int NUM_SENSE    = 2,
    parameter int SETTLE_TICKS = 3,
    localparam int SCNT_W = $clog2(SETTLE_TICKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 keep,
    input  logic                 start,
    input  logic [NUM_SENSE-1:0] sense_in,
    input  logic                 wake_en,
    output logic                 pwr,
    output logic                 hit
);

    localparam logic [SCNT_W-1:0] SETTLE_LAST = SCNT_W'(SETTLE_TICKS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [SCNT_W-1:0] scnt;
        logic              hit;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (!keep) begin
            // Leaving STOP mode or disabling the check drops everything.
            sq_d.st   = SEQ_IDLE;
            sq_d.scnt = '0;
            sq_d.hit  = 1'b0;
        end else begin
            unique case (sq_q.st)
                SEQ_IDLE: begin
                    if (start) begin
                        sq_d.st   = SEQ_SETTLE;
                        sq_d.scnt = '0;
                    end
                end
                SEQ_SETTLE: begin
                    if (tick) begin
                        if (sq_q.scnt == SETTLE_LAST) begin
                            sq_d.st   = SEQ_IDLE;
                            sq_d.scnt = '0;
                            if (wake_en && (|sense_in)) begin
                                sq_d.hit = 1'b1;
                            end
                        end else begin
                            sq_d.scnt = sq_q.scnt + 1'b1;
                        end
                    end
                end
                default: sq_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SEQ_IDLE, scnt: '0, hit: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign pwr = (sq_q.st == SEQ_SETTLE);
    assign hit = sq_q.hit;

    assert_pwr_in_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr |-> $past(keep));

    assert_hit_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && keep) |=> hit);

endmodule

// File: rtl/wake_watchdog.sv
module wake_watchdog
    import wake_wdt_pkg::*;
#(
    parameter int NUM_SENSE    = 2,
    parameter int PERIOD_SHORT = 16,
    parameter int PERIOD_LONG  = 32,
    parameter int SETTLE_TICKS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 stop_mode,
    input  logic                 tick_en,
    input  logic [NUM_SENSE-1:0] sense_in,
    input  logic                 sense_wake_en,
    output logic                 sense_pwr,
    output logic                 reset_req,
    output logic                 irq_req,
    output logic                 wake_req
);

    ctrl_t ctrl;
    logic  restart;
    logic  timeout;
    logic  active;
    logic  count_en;
    logic  sense_hit;
    logic  rst_req_d, rst_req_q;

    assign active   = ctrl.rst_en | ctrl.irq_en | ctrl.cyc_en;
    // In STOP mode the watchdog by itself does not count.
    assign count_en = stop_mode ? (ctrl.irq_en | ctrl.cyc_en) : 1'b1;

    wdt_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wdata   (reg_wdata),
        .timeout (timeout),
        .ctrl    (ctrl),
        .restart (restart),
        .rdata   (reg_rdata)
    );

    wdt_timebase #(
        .PERIOD_SHORT (PERIOD_SHORT),
        .PERIOD_LONG  (PERIOD_LONG)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .active   (active),
        .count_en (count_en),
        .restart  (restart),
        .sel      (ctrl.sel),
        .timeout  (timeout)
    );

    wdt_sense_seq #(
        .NUM_SENSE    (NUM_SENSE),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .keep     (stop_mode & ctrl.cyc_en),
        .start    (timeout & stop_mode & ctrl.cyc_en),
        .sense_in (sense_in),
        .wake_en  (sense_wake_en),
        .pwr      (sense_pwr),
        .hit      (sense_hit)
    );

    always_comb begin
        rst_req_d = rst_req_q | (timeout & ~stop_mode & ctrl.rst_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= rst_req_d;
        end
    end

    assign reset_req = rst_req_q;
    assign irq_req   = stop_mode & ctrl.irq_en & ctrl.flag;
    assign wake_req  = irq_req | sense_hit;

    assert_reset_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req);

    assert_reset_from_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(!stop_mode));

    assert_stop_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !ctrl.irq_en && !ctrl.cyc_en) |-> !timeout);

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> reg_rdata[BIT_FLAG]);

    assert_off_no_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !timeout);

endmodule

// File: tb/wake_watchdog_bench.sv
module wake_watchdog_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       stop_mode = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] sense_in = 2'b00;
    logic       sense_wake_en = 1'b0;
    logic       sense_pwr, reset_req, irq_req, wake_req;

    int n_vec  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    wake_watchdog u_wake_watchdog (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .stop_mode     (stop_mode),
        .tick_en       (tick_en),
        .sense_in      (sense_in),
        .sense_wake_en (sense_wake_en),
        .sense_pwr     (sense_pwr),
        .reset_req     (reset_req),
        .irq_req       (irq_req),
        .wake_req      (wake_req)
    );

    // Each entry: {write data, expected read-back}; ticks are off.
    localparam logic [15:0] REG_VEC [10] = '{
        16'h0000, 16'hC000, 16'h2000, 16'h0D0D, 16'h0200,
        16'h0909, 16'h1010, 16'h0010, 16'h1F1D, 16'h0414
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr_en = 1'b0; stop_mode = 1'b0;
        tick_en = 1'b0; sense_in = 2'b00; sense_wake_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(reg_rdata, 8'h00, "R1 reset rdata");
        chk({4'h0, sense_pwr, reset_req, irq_req, wake_req}, 8'h00, "R1 reset outputs");

        // R1 and R3 register table
        for (int i = 0; i < 10; i++) begin
            wr(REG_VEC[i][15:8]);
            chk(reg_rdata, REG_VEC[i][7:0], "R1 R3 register vector");
        end

        // R2: no enables, ticks running
        do_reset();
        tick_en = 1'b1;
        wr(8'h01);
        repeat (80) @(negedge clk);
        chk(reg_rdata, 8'h01, "R2 no flag while off");
        chk({7'h0, reset_req}, 8'h00, "R2 no reset while off");

        // R4 and R9: RUN-mode watchdog, short period
        do_reset();
        tick_en = 1'b1;
        wr(8'h10);
        repeat (15) @(negedge clk);
        chk({7'h0, reset_req}, 8'h00, "R4 before end");
        @(negedge clk);
        chk({7'h0, reset_req}, 8'h01, "R4 R9 reset at end");
        chk(reg_rdata, 8'h12, "R7 flag on timeout");
        repeat (5) @(negedge clk);
        chk({7'h0, reset_req}, 8'h01, "R4 reset held");

        // R6: restart command
        do_reset();
        tick_en = 1'b1;
        wr(8'h10);
        repeat (10) @(negedge clk);
        wr(8'h30);
        chk(reg_rdata, 8'h10, "R6 restart reads 0");
        repeat (15) @(negedge clk);
        chk({7'h0, reset_req}, 8'h00, "R6 no early reset");
        @(negedge clk);
        chk({7'h0, reset_req}, 8'h01, "R6 reset after full period");

        // R7 and R8: flag handling in RUN mode
        do_reset();
        tick_en = 1'b1;
        wr(8'h08);
        repeat (16) @(negedge clk);
        chk(reg_rdata, 8'h0A, "R7 flag set");
        chk({7'h0, irq_req}, 8'h00, "R8 no irq in RUN");
        wr(8'h08);
        chk(reg_rdata, 8'h0A, "R7 write 0 keeps flag");
        wr(8'h0A);
        chk(reg_rdata, 8'h08, "R7 write 1 clears flag");
        repeat (15) @(negedge clk);
        chk(reg_rdata, 8'h08, "R7 clear restarted count");
        @(negedge clk);
        chk(reg_rdata, 8'h0A, "R7 flag after new period");

        // R8: STOP mode interrupt, then R9 long period
        stop_mode = 1'b1;
        #1;
        chk({6'h0, irq_req, wake_req}, 8'h03, "R8 irq and wake in STOP");
        wr(8'h0B);
        chk({7'h0, irq_req}, 8'h00, "R8 irq drops on clear");
        repeat (31) @(negedge clk);
        chk({7'h0, irq_req}, 8'h00, "R9 long period not yet");
        @(negedge clk);
        chk({6'h0, irq_req, wake_req}, 8'h03, "R9 R8 long period irq");

        // R5: watchdog frozen in STOP mode
        do_reset();
        tick_en = 1'b1;
        wr(8'h10);
        repeat (8) @(negedge clk);
        stop_mode = 1'b1;
        repeat (50) @(negedge clk);
        chk({7'h0, reset_req}, 8'h00, "R5 frozen in STOP");
        stop_mode = 1'b0;
        repeat (7) @(negedge clk);
        chk({7'h0, reset_req}, 8'h00, "R5 resumed count");
        @(negedge clk);
        chk({7'h0, reset_req}, 8'h01, "R5 resumed timeout");

        // R10: cyclic check
        do_reset();
        tick_en = 1'b1;
        stop_mode = 1'b1;
        sense_wake_en = 1'b1;
        wr(8'h04);
        repeat (15) @(negedge clk);
        chk({7'h0, sense_pwr}, 8'h00, "R10 pwr before period");
        @(negedge clk);
        chk({7'h0, sense_pwr}, 8'h01, "R10 pwr on");
        repeat (2) @(negedge clk);
        chk({7'h0, sense_pwr}, 8'h01, "R10 pwr settle");
        @(negedge clk);
        chk({6'h0, sense_pwr, wake_req}, 8'h00, "R10 pwr off, no hit");
        sense_in = 2'b01;
        repeat (15) @(negedge clk);
        chk({6'h0, sense_pwr, wake_req}, 8'h02, "R10 before sample");
        @(negedge clk);
        chk({6'h0, sense_pwr, wake_req}, 8'h01, "R10 hit wakes");
        stop_mode = 1'b0;
        @(negedge clk);
        chk({7'h0, wake_req}, 8'h00, "R10 wake cleared in RUN");

        // R10: sensor wake disabled
        do_reset();
        tick_en = 1'b1;
        stop_mode = 1'b1;
        sense_in = 2'b10;
        wr(8'h04);
        repeat (19) @(negedge clk);
        chk({6'h0, sense_pwr, wake_req}, 8'h00, "R10 no wake when disabled");

        finish_run();
    end

endmodule